// File: doc/BRIEF.md
# SD Data-Line CRC16 Generator and Checker

This unit produces and verifies the CRC16 check words of one SD data block, in either single-line or four-line bus width. In four-line mode it runs four separate CRC16 engines. Each engine sees only the serial bit stream of its own data line. No CRC is formed over packed bytes. When the block has been transferred, each line carries its own 16 check bits, then an end bit.

The surrounding controller pulses `blk_start` with the wanted bus width and direction. It then offers one line sample per `bit_vld` strobe on `dat_in`. When transmitting, `dat_in` is the data nibble (or bit) to send. The unit sends it out registered on `dat_out`, then follows with the CRC bits and the end bit by itself. When receiving, `dat_in` is what the lines carried. The unit compares the incoming check bits against its own and reports a per-line mismatch vector and an overall pass flag when the end bit arrives. Start-bit framing and the command line belong to other units.

Top module: `sdcrc_unit`

## Requirements
- R1: After reset `dat_out` is 4'b1111, and `blk_done`, `crc_ok` and `crc_bad` are all 0.
- R2: In four-line mode (`wide_mode`=1) each line i keeps its own CRC16 with polynomial x^16+x^12+x^5+1 and a zero start value. The CRC covers only the bits seen on line i. A byte goes high nibble first, with nibble bit 3 on line 3 and bit 0 on line 0.
- R3: In single-line mode (`wide_mode`=0) only line 0 is used. A byte goes MSB first. `dat_in[3:1]` is ignored, `dat_out[3:1]` stays 1 and `crc_bad[3:1]` stays 0.
- R4: When transmitting (`tx_mode`=1), each data strobe puts the offered active-line bits on `dat_out` at that clock edge. Next come 16 CRC bits per active line, MSB first, one per strobe. Last comes an end bit of 1 on every line.
- R5: When receiving (`tx_mode`=0), `dat_out` stays 4'b1111. Each of the 16 check bits on an active line is compared with the computed CRC. A bit of `crc_bad` is set for each line that has any difference. `crc_ok` is set at the end bit only if no active line differs.
- R6: `blk_done` is a one-cycle pulse at the edge that takes the end bit. `crc_ok` and `crc_bad` then hold until the next `blk_start`.
- R7: Only cycles with `bit_vld`=1 advance the block. On other cycles `dat_in` has no effect and `dat_out` holds its value.
- R8: `blk_start` restarts the block at any time. It clears all CRCs and results, latches `wide_mode` and `tx_mode`, and returns `dat_out` to 4'b1111.
- R9: The data phase lasts BLK_BYTES*2 strobes in four-line mode and BLK_BYTES*8 strobes in single-line mode. It is followed by 16 CRC strobes and one end-bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Begin a new block (clears CRCs, latches modes) |
| wide_mode | input | 1 | 1 = four data lines, 0 = line 0 only |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| bit_vld | input | 1 | One line-bit time is present on `dat_in` |
| dat_in | input | 4 | Data to send (transmit) or line samples (receive) |
| dat_out | output | 4 | Registered line drive values, idle high |
| blk_done | output | 1 | Pulse when the end bit is taken |
| crc_ok | output | 1 | Receive pass flag, valid from `blk_done` |
| crc_bad | output | 4 | Per-line receive mismatch flags |

## Verification
The bench builds the unit with BLK_BYTES=4. This keeps a block to 8 data strobes per line in four-line mode and 32 in single-line mode. Every corner can then be reached in a few dozen cycles each: the data/CRC and CRC/end boundaries, a check-bit error on any single line or on several lines, and garbage on the unused lines in single-line mode. The length-dependent counter limits are the same arithmetic as at the default of 512 bytes, only smaller.

// File: rtl/sdcrc_pkg.sv
package sdcrc_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_CRC,
        PH_END
    } phase_e;

    // One serial step of the CRC16 shift register.
    function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] c,
                                                     input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/sdcrc_lane.sv
module sdcrc_lane
    import sdcrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic             shift,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_o
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_o <= '0;
        end else if (upd) begin
            crc_o <= crc16_step(crc_o, bit_in);
        end else if (shift) begin
            crc_o <= {crc_o[CRC_W-2:0], 1'b0};
        end
    end

    // Restart leaves a zero CRC behind.
    assert_lane_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_o == '0));

    // Without a strobe the engine keeps its value.
    assert_lane_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr && !upd && !shift) |=> $stable(crc_o));

endmodule

// File: rtl/sdcrc_seq.sv
module sdcrc_seq
    import sdcrc_pkg::*;
#(
    parameter int BLK_BYTES = 512
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   blk_start,
    input  logic   bit_vld,
    input  logic   wide_q,
    output phase_e phase_o,
    output logic   done_o
);

    localparam int NIB_STEPS = BLK_BYTES * 2;
    localparam int BIT_STEPS = BLK_BYTES * 8;
    localparam int CW        = $clog2(BIT_STEPS) + 1;
    localparam logic [CW-1:0] LAST_NIB = CW'(NIB_STEPS - 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(BIT_STEPS - 1);
    localparam logic [CW-1:0] LAST_CRC = CW'(CRC_W - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_data;

    assign last_data = wide_q ? LAST_NIB : LAST_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_IDLE;
            cnt     <= '0;
            done_o  <= 1'b0;
        end else if (blk_start) begin
            phase_o <= PH_DATA;
            cnt     <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (bit_vld) begin
                unique case (phase_o)
                    PH_DATA: begin
                        if (cnt == last_data) begin
                            phase_o <= PH_CRC;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_CRC: begin
                        if (cnt == LAST_CRC) begin
                            phase_o <= PH_END;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_END: begin
                        phase_o <= PH_IDLE;
                        done_o  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_start_enters_data_R8: assert property (@(posedge clk) disable iff (rst)
        blk_start |=> (phase_o == PH_DATA));

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld && !blk_start) |=> $stable(phase_o));

    assert_done_from_end_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(phase_o) == PH_END));

endmodule

// File: rtl/sdcrc_unit.sv
module sdcrc_unit
    import sdcrc_pkg::*;
#(
    parameter int BLK_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       blk_start,
    input  logic       wide_mode,
    input  logic       tx_mode,
    input  logic       bit_vld,
    input  logic [3:0] dat_in,
    output logic [3:0] dat_out,
    output logic       blk_done,
    output logic       crc_ok,
    output logic [3:0] crc_bad
);

    logic             wide_q;
    logic             tx_q;
    phase_e           phase;
    logic [LANES-1:0] active;
    logic [LANES-1:0] msb;
    logic             data_vld;
    logic             crc_vld;
    logic             end_vld;

    assign active   = wide_q ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
    assign data_vld = bit_vld && !blk_start && (phase == PH_DATA);
    assign crc_vld  = bit_vld && !blk_start && (phase == PH_CRC);
    assign end_vld  = bit_vld && !blk_start && (phase == PH_END);

    sdcrc_seq #(.BLK_BYTES(BLK_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .blk_start (blk_start),
        .bit_vld   (bit_vld),
        .wide_q    (wide_q),
        .phase_o   (phase),
        .done_o    (blk_done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CRC_W-1:0] crc;
        sdcrc_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .clr    (blk_start),
            .upd    (data_vld && active[g]),
            .shift  (crc_vld && active[g]),
            .bit_in (dat_in[g]),
            .crc_o  (crc)
        );
        assign msb[g] = crc[CRC_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q  <= 1'b0;
            tx_q    <= 1'b0;
            dat_out <= '1;
            crc_bad <= '0;
            crc_ok  <= 1'b0;
        end else if (blk_start) begin
            wide_q  <= wide_mode;
            tx_q    <= tx_mode;
            dat_out <= '1;
            crc_bad <= '0;
            crc_ok  <= 1'b0;
        end else if (tx_q) begin
            if (data_vld) begin
                dat_out <= (dat_in & active) | ~active;
            end else if (crc_vld) begin
                dat_out <= (msb & active) | ~active;
            end else if (end_vld) begin
                dat_out <= '1;
            end
        end else begin
            if (crc_vld) begin
                crc_bad <= crc_bad | ((dat_in ^ msb) & active);
            end
            if (end_vld) begin
                crc_ok <= (crc_bad == '0);
            end
        end
    end

    assert_rx_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !tx_q |-> (dat_out == 4'hF));

    assert_narrow_unused_R3: assert property (@(posedge clk) disable iff (rst)
        !wide_q |-> ((dat_out[3:1] == 3'b111) && (crc_bad[3:1] == 3'b000)));

    assert_pass_matches_R5: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !tx_q) |-> (crc_ok == (crc_bad == '0)));

    assert_end_bit_high_R4: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> (dat_out == 4'hF));

    assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!blk_start && (phase == PH_IDLE)) |=> ($stable(crc_ok) && $stable(crc_bad)));

endmodule

// File: tb/test_sdcrc_unit.sv
module test_sdcrc_unit;

    localparam int BLK = 4;
    localparam int NV  = 9;

    // {wide, tx, gap, flip[3:0], data[31:0]}
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 4'b0000, 32'h0000_0000},
        {1'b1, 1'b1, 1'b1, 4'b0000, 32'hA5C3_1F7E},
        {1'b0, 1'b1, 1'b0, 4'b0000, 32'h1234_5678},
        {1'b1, 1'b0, 1'b0, 4'b0000, 32'hDEAD_BEEF},
        {1'b1, 1'b0, 1'b0, 4'b0100, 32'hDEAD_BEEF},
        {1'b0, 1'b0, 1'b0, 4'b0000, 32'h0F0F_55AA},
        {1'b0, 1'b0, 1'b1, 4'b0001, 32'h0F0F_55AA},
        {1'b1, 1'b0, 1'b1, 4'b1001, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 1'b0, 4'b1110, 32'h8001_7FFE}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       blk_start = 1'b0;
    logic       wide_mode = 1'b0;
    logic       tx_mode = 1'b0;
    logic       bit_vld = 1'b0;
    logic [3:0] dat_in = 4'h0;
    logic [3:0] dat_out;
    logic       blk_done;
    logic       crc_ok;
    logic [3:0] crc_bad;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdcrc_unit #(.BLK_BYTES(BLK)) i_sdcrc_unit (
        .clk       (clk),
        .rst       (rst),
        .blk_start (blk_start),
        .wide_mode (wide_mode),
        .tx_mode   (tx_mode),
        .bit_vld   (bit_vld),
        .dat_in    (dat_in),
        .dat_out   (dat_out),
        .blk_done  (blk_done),
        .crc_ok    (crc_ok),
        .crc_bad   (crc_bad)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [31:0] bits, input int n);
        logic [15:0] c;
        logic fb;
        c = 16'h0000;
        for (int k = 0; k < n; k++) begin
            fb = bits[n-1-k] ^ c[15];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic run_block(input logic wide, input logic tx, input logic gap,
                             input logic [3:0] flip, input logic [31:0] data);
        logic [3:0]  strm [32];
        logic [31:0] lbits [4];
        logic [15:0] expc [4];
        logic [3:0]  act;
        logic [3:0]  drv;
        logic [3:0]  exp_out;
        int          n;
        act = wide ? 4'hF : 4'h1;
        n   = wide ? 2 * BLK : 8 * BLK;
        for (int t = 0; t < n; t++) begin
            if (wide) begin
                logic [7:0] by;
                by = data[31 - 8*(t/2) -: 8];
                strm[t] = (t % 2 == 0) ? by[7:4] : by[3:0];
            end else begin
                logic b;
                b = data[31-t];
                strm[t] = {~b, b, ~b, b};
            end
        end
        for (int i = 0; i < 4; i++) begin
            lbits[i] = '0;
            for (int t = 0; t < n; t++) lbits[i][n-1-t] = strm[t][i];
            expc[i] = ref_crc(lbits[i], n);
        end
        @(negedge clk);
        blk_start = 1'b1; wide_mode = wide; tx_mode = tx; bit_vld = 1'b0;
        @(negedge clk);
        blk_start = 1'b0;
        chk("R8 dat_out high after start", dat_out, 4'hF);
        for (int t = 0; t < n; t++) begin
            dat_in = strm[t]; bit_vld = 1'b1;
            @(negedge clk);
            exp_out = tx ? ((strm[t] & act) | ~act) : 4'hF;
            if (tx) chk(wide ? "R4 R2 tx data" : "R4 R3 tx data", dat_out, exp_out);
            if (gap) begin
                bit_vld = 1'b0; dat_in = ~strm[t];
                @(negedge clk);
                chk("R7 hold without strobe", dat_out, exp_out);
            end
        end
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < 4; i++)
                drv[i] = act[i] ? (expc[i][15-k] ^ (flip[i] && k == 3)) : ~expc[0][15-k];
            dat_in = tx ? 4'h0 : drv; bit_vld = 1'b1;
            @(negedge clk);
            if (tx) begin
                exp_out = 4'hF;
                for (int i = 0; i < 4; i++) if (act[i]) exp_out[i] = expc[i][15-k];
                chk(wide ? "R4 R2 tx crc bit" : "R4 R3 tx crc bit", dat_out, exp_out);
            end else begin
                chk("R5 rx drives idle", dat_out, 4'hF);
            end
            if (gap) begin
                bit_vld = 1'b0; dat_in = ~dat_in;
                @(negedge clk);
            end
        end
        chk("R9 no done before end bit", blk_done, 1'b0);
        dat_in = 4'hF; bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        chk("R6 R9 done at end bit", blk_done, 1'b1);
        if (tx) begin
            chk("R4 end bit", dat_out, 4'hF);
        end else begin
            chk(wide ? "R5 R2 crc_bad" : "R5 R3 crc_bad", crc_bad, flip & act);
            chk("R5 crc_ok", crc_ok, (flip & act) == 4'h0);
        end
        @(negedge clk);
        chk("R6 done one cycle", blk_done, 1'b0);
        repeat (3) @(negedge clk);
        if (!tx) begin
            chk("R6 result held", {crc_ok, crc_bad}, {((flip & act) == 4'h0), flip & act});
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset dat_out", dat_out, 4'hF);
        chk("R1 reset flags", {blk_done, crc_ok, crc_bad}, 6'b0);

        for (int v = 0; v < NV; v++) begin
            run_block(VEC[v][38], VEC[v][37], VEC[v][36], VEC[v][35:32], VEC[v][31:0]);
        end

        // Restart in the middle of a four-line transmit block.
        @(negedge clk);
        blk_start = 1'b1; wide_mode = 1'b1; tx_mode = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        for (int t = 0; t < 3; t++) begin
            dat_in = 4'h6; bit_vld = 1'b1;
            @(negedge clk);
        end
        bit_vld = 1'b0;
        chk("R4 partial data driven", dat_out, 4'h6);
        run_block(1'b1, 1'b1, 1'b0, 4'b0000, 32'h3C96_E10B);

        // Restart a failing receive block; the new block must pass.
        @(negedge clk);
        blk_start = 1'b1; wide_mode = 1'b1; tx_mode = 1'b0;
        @(negedge clk);
        blk_start = 1'b0;
        for (int t = 0; t < 2 * BLK + 2; t++) begin
            dat_in = 4'h9; bit_vld = 1'b1;
            @(negedge clk);
        end
        bit_vld = 1'b0;
        run_block(1'b1, 1'b0, 1'b0, 4'b0000, 32'h5555_AAAA);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule